// File: doc/BRIEF.md
# Unlock-Gated Channel Trigger

This block lets software fire one pulse on a chosen output channel by writing bytes into an 8-bit trigger field. Each write reaches the block as a byte together with a one-cycle load strobe. A small state machine follows successive writes against a fixed unlock code. The write that comes right after a complete code is read as a channel number. If the number names a real channel, that channel's trigger line carries a single registered high pulse. A downstream pulse generator that reacts to rising edges uses this pulse.

The unlock code is a parameter and defaults to the four bytes 0xDE, 0xAD, 0xBE, 0xEF. A write that breaks the code sends the machine back to idle. If that write equals the first code byte, it counts as a fresh first step. Channel numbers run from 1 to the channel count, which defaults to 6. Any other number is dropped silently.

Top module: `seq_gated_trigger`

## Requirements
- R1: A synchronous active-low reset clears the unlock progress and drives every trigger line low. A channel write that follows a reset produces no pulse unless a full unlock code precedes it.
- R2: The unlock code is the bytes 0xDE, 0xAD, 0xBE, 0xEF, each presented with the load strobe, in exactly that order. A channel write without a complete preceding code produces no pulse.
- R3: The first strobed write after a complete code is a channel number. The value N (1 to 6) drives trig_o bit N-1 high in the cycle that follows the clock edge that sampled the strobe.
- R4: At most one trigger line is high at any time, and only the selected channel's line rises.
- R5: A channel value of 0 or greater than 6 (for example 7, 0xDE or 0xFF) produces no pulse and no error indication.
- R6: After the channel write the machine returns to idle, whether or not the value was valid. A further number needs a new full unlock code.
- R7: Each trigger is a low-to-high step of exactly one clock cycle: the line is low before the pulse and low in the cycle after it.
- R8: While the load strobe is low, changes on the data input have no effect on unlock progress.
- R9: A strobed write that does not match the expected code byte returns the machine to idle. If that write equals 0xDE, it counts as the first code byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_ld_i | input | 1 | One-cycle strobe marking a new trigger-field write |
| wr_val_i | input | 8 | Byte written to the trigger field |
| trig_o | output | 6 | Per-channel trigger pulses; bit N-1 belongs to channel N |

## Verification
The assertions take for granted that the load strobe lasts one cycle per write. With that, a channel write can never repeat while the machine is armed. They also take for granted that the data byte is known whenever the strobe is high. The stimulus raises the strobe for exactly one cycle, always with a defined byte. It leaves at least one idle cycle between writes. Where the data input changes without a strobe, the change is deliberate and is checked as ignored.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

  // Classification of one clock cycle as seen by the unlock tracker
  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,  // no strobe this cycle
    EV_ADVANCE = 3'd1,  // byte matches the expected code byte
    EV_RESTART = 3'd2,  // mismatch, but byte equals the first code byte
    EV_BREAK   = 3'd3,  // mismatch, back to idle
    EV_CHANNEL = 3'd4   // armed: this byte is a channel number
  } step_ev_t;

endpackage

// File: rtl/seq_matcher.sv
module seq_matcher
  import seqtrig_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEQ_LEN = 4,
  parameter logic [SEQ_LEN*DATA_W-1:0] SEQ = 32'hDEAD_BEEF,
  localparam int PROG_W = $clog2(SEQ_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              armed_o,
  output step_ev_t          ev_o,
  output logic [PROG_W-1:0] prog_o
);

  localparam logic [PROG_W-1:0] PROG_FULL = PROG_W'(SEQ_LEN);

  // First code byte sits in the most significant slot
  function automatic logic [DATA_W-1:0] seq_at(input logic [PROG_W-1:0] idx);
    int unsigned k;
    k = (int'(idx) < SEQ_LEN) ? int'(idx) : 0;
    return SEQ[(SEQ_LEN-1-k)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [PROG_W-1:0] next_prog(input step_ev_t ev,
                                                  input logic [PROG_W-1:0] p);
    case (ev)
      EV_ADVANCE: return p + PROG_W'(1);
      EV_RESTART: return PROG_W'(1);
      EV_BREAK,
      EV_CHANNEL: return '0;
      default:    return p;
    endcase
  endfunction

  logic [PROG_W-1:0] prog_q;
  logic [DATA_W-1:0] expect_byte;
  logic              armed;
  step_ev_t          ev;

  assign armed       = (prog_q == PROG_FULL);
  assign expect_byte = seq_at(prog_q);

  always_comb begin
    if (!ld_i)                      ev = EV_NONE;
    else if (armed)                 ev = EV_CHANNEL;
    else if (val_i == expect_byte)  ev = EV_ADVANCE;
    else if (val_i == seq_at('0))   ev = EV_RESTART;
    else                            ev = EV_BREAK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prog_q <= '0;
    else        prog_q <= next_prog(ev, prog_q);
  end

  assign armed_o = armed;
  assign ev_o    = ev;
  assign prog_o  = prog_q;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(prog_q)); // R8
  AST_CHAN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && armed) |=> (prog_q == '0)); // R6
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RESTART) |=> (prog_q == PROG_W'(1))); // R9
  AST_PROG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q <= PROG_FULL); // R2

endmodule

// File: rtl/chan_decoder.sv
module chan_decoder #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 6
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              valid_o,
  output logic [NUM_CH-1:0] onehot_o
);

  function automatic logic chan_ok(input logic [DATA_W-1:0] v);
    return (v != '0) && (int'(v) <= NUM_CH);
  endfunction

  assign valid_o = chan_ok(val_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    assign onehot_o[c] = (val_i == DATA_W'(c + 1));
  end

endmodule

// File: rtl/trig_pulse_reg.sv
module trig_pulse_reg #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [NUM_CH-1:0] sel_i,
  output logic [NUM_CH-1:0] trig_o
);

  logic [NUM_CH-1:0] trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      trig_q <= '0;
    else if (fire_i) trig_q <= sel_i;
    else             trig_q <= '0;
  end

  assign trig_o = trig_q;

  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_q) |=> (trig_q == '0)); // R7
  AST_ONEHOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_q)); // R4

endmodule

// File: rtl/seq_gated_trigger.sv
module seq_gated_trigger
  import seqtrig_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEQ_LEN = 4,
  parameter logic [SEQ_LEN*DATA_W-1:0] SEQ = 32'hDEAD_BEEF,
  parameter int NUM_CH  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ld_i,
  input  logic [DATA_W-1:0] wr_val_i,
  output logic [NUM_CH-1:0] trig_o
);

  localparam int PROG_W = $clog2(SEQ_LEN + 1);

  logic              armed;
  step_ev_t          step_ev;
  logic [PROG_W-1:0] prog;
  logic              chan_valid;
  logic [NUM_CH-1:0] chan_sel;
  logic              fire;

  seq_matcher #(
    .DATA_W (DATA_W),
    .SEQ_LEN(SEQ_LEN),
    .SEQ    (SEQ)
  ) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (wr_ld_i),
    .val_i  (wr_val_i),
    .armed_o(armed),
    .ev_o   (step_ev),
    .prog_o (prog)
  );

  chan_decoder #(
    .DATA_W(DATA_W),
    .NUM_CH(NUM_CH)
  ) u_dec (
    .val_i   (wr_val_i),
    .valid_o (chan_valid),
    .onehot_o(chan_sel)
  );

  assign fire = (step_ev == EV_CHANNEL) && chan_valid;

  trig_pulse_reg #(
    .NUM_CH(NUM_CH)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire_i(fire),
    .sel_i (chan_sel),
    .trig_o(trig_o)
  );

  AST_NO_PULSE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_o) |-> $past(wr_ld_i && armed)); // R3
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ld_i && armed && !chan_valid) |=> (trig_o == '0)); // R5
  AST_DECODE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ld_i |-> (chan_valid == (|chan_sel))); // R5
  AST_ARMED_FROM_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev == EV_ADVANCE && prog == PROG_W'(SEQ_LEN - 1)) |=> armed); // R2

endmodule

// File: tb/tb_seq_gated_trigger.sv
module tb_seq_gated_trigger;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ld = 1'b0;
  logic [7:0] wr_val = 8'h00;
  logic [5:0] trig;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  seq_gated_trigger dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ld_i (wr_ld),
    .wr_val_i(wr_val),
    .trig_o  (trig)
  );

  // {byte written with strobe, expected trig_o in the cycle after}
  localparam int NV = 61;
  localparam logic [13:0] VEC [NV] = '{
    // R2 R3: channel 3 -> bit 2
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h03,6'h04},
    // R3 upper boundary: channel 6 -> bit 5
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h06,6'h20},
    // R3 lower boundary: channel 1 -> bit 0
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h01,6'h01},
    // R5 channel 0, then R6 next number without code is dropped
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h00,6'h00},{8'h05,6'h00},
    // R5 channel 7
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h07,6'h00},
    // R9 repeated first byte counts as new first step
    {8'hDE,6'h00},{8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h02,6'h02},
    // R9 break in the middle returns to idle
    {8'hDE,6'h00},{8'hAD,6'h00},{8'h00,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h02,6'h00},
    // R2 R9 wrong order, last byte restarts, channel 4 -> bit 3
    {8'hEF,6'h00},{8'hBE,6'h00},{8'hAD,6'h00},{8'hDE,6'h00},
    {8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h04,6'h08},
    // R5 R6 channel 0xDE is not a first step
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'hDE,6'h00},
    {8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'h01,6'h00},
    // R2 channel without any code
    {8'h03,6'h00},
    // R5 channel 0xFF
    {8'hDE,6'h00},{8'hAD,6'h00},{8'hBE,6'h00},{8'hEF,6'h00},{8'hFF,6'h00}
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_o actual %b expected %b", tag, act, exp);
    end
  endtask

  // Strobed write; checks the pulse cycle and the cycle after it (R7)
  task automatic wr(input logic [7:0] v, input logic [5:0] exp, input string tag);
    @(negedge clk);
    check({tag, " R7 low before"}, trig, 6'h00);
    wr_ld  = 1'b1;
    wr_val = v;
    @(negedge clk);
    wr_ld = 1'b0;
    check(tag, trig, exp);
    @(negedge clk);
    check({tag, " R7 one cycle"}, trig, 6'h00);
  endtask

  task automatic sync_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 trig low in reset", trig, 6'h00);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", trig, 6'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][13:6], VEC[i][5:0], $sformatf("table entry %0d", i));
    end

    // R8: data changes without strobe are ignored
    wr(8'hDE, 6'h00, "R8 setup");
    wr(8'hAD, 6'h00, "R8 setup");
    @(negedge clk); wr_val = 8'hBE;
    @(negedge clk); wr_val = 8'hEF;
    @(negedge clk); wr_val = 8'h02;
    @(negedge clk);
    check("R8 no strobe no pulse", trig, 6'h00);
    wr(8'hBE, 6'h00, "R8 code continues");
    wr(8'hEF, 6'h00, "R8 code continues");
    wr(8'h02, 6'h02, "R8 progress kept");

    // R1: reset part way through the code
    wr(8'hDE, 6'h00, "R1 setup");
    wr(8'hAD, 6'h00, "R1 setup");
    wr(8'hBE, 6'h00, "R1 setup");
    sync_reset();
    wr(8'hEF, 6'h00, "R1 after reset");
    wr(8'h05, 6'h00, "R1 progress cleared");

    // R1: reset while armed
    wr(8'hDE, 6'h00, "R1 setup");
    wr(8'hAD, 6'h00, "R1 setup");
    wr(8'hBE, 6'h00, "R1 setup");
    wr(8'hEF, 6'h00, "R1 setup");
    sync_reset();
    wr(8'h03, 6'h00, "R1 armed state cleared");

    // R4 R3: back-to-back channels after fresh codes
    wr(8'hDE, 6'h00, "R4 setup");
    wr(8'hAD, 6'h00, "R4 setup");
    wr(8'hBE, 6'h00, "R4 setup");
    wr(8'hEF, 6'h00, "R4 setup");
    wr(8'h05, 6'h10, "R4 only channel 5");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule